// File: doc/BRIEF.md
# Port Bus Router With Open-Bus Default

This block connects a CPU core's port input/output requests to a small set of peripheral port windows. The core hands over one request at a time: a read or a write, byte or word wide, at a 16-bit port number. That port number is either an 8-bit immediate padded with zeros or a full 16-bit value taken from a register. The bus itself moves one byte per cycle. A word request becomes two byte cycles: the low byte goes to port N and the high byte goes to port N+1.

Each byte cycle is decoded against a parameter table of windows. Each window has a base and a size, and every port inside a window selects that window's peripheral. A byte that falls in no window is handled by a built-in open-bus responder. That responder returns 0xFF on reads and drops writes without any peripheral seeing them. Because the two halves of a word are decoded separately, one half can reach a peripheral while the other half gets the default answer. The core is told the request has finished only after every byte cycle is complete.

Top module: `pio_bus`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and per_sel is all zero.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1, and req_ready stays 0 until the request has finished. The first byte cycle occupies the clock cycle right after the accepting edge. done is high for exactly one cycle: the cycle after the last byte cycle.
- R3: When req_imm_mode is 1, the port number is {8'h00, req_imm}. Otherwise it is req_dx.
- R4: A byte cycle at port P sets per_sel bit i when P minus WIN_BASE[i], taken modulo 2^16, is less than WIN_SIZE[i]. Where windows overlap, only the lowest matching index is set. per_sel has at most one bit set.
- R5: A read byte from a port outside every window reads as 8'hFF.
- R6: A write byte to a port outside every window leaves per_sel all zero, so no peripheral stores anything.
- R7: A word access makes two consecutive byte cycles. The first is at port N and carries data bits [7:0]. The second is at port N+1 and carries data bits [15:8]. Read data is assembled the same way, little-endian.
- R8: The port number of the second byte is N+1 modulo 2^16, so port 0xFFFF is followed by port 0x0000.
- R9: Each byte of a word is decoded on its own, so one half may select a peripheral while the other half is served by the default responder.
- R10: At done, a byte read gives rdata = {8'h00, byte} and any write gives rdata = 16'h0000.
- R11: During a byte cycle, per_we equals the request's write flag and per_port shows the port number. Outside byte cycles, per_we and per_sel are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_imm_mode | input | 1 | 1 = port from req_imm, 0 = port from req_dx |
| req_imm | input | 8 | Immediate port number |
| req_dx | input | 16 | Register port number |
| req_wdata | input | 16 | Write data (byte access uses [7:0]) |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | 16 | Read data, valid while done is high |
| per_sel | output | NUM_WIN | One-hot window select for the current byte cycle |
| per_we | output | 1 | Write strobe of the current byte cycle |
| per_port | output | 16 | Port number of the current byte cycle |
| per_wdata | output | 8 | Write byte of the current byte cycle |
| per_rdata | input | 8*NUM_WIN | Read byte from each window, window i at [8i+7:8i] |

## Verification
The first byte cycle is due in the cycle right after the accepting edge, and for a word the second byte cycle follows one cycle later. done comes one cycle after the last byte cycle, and req_ready returns in the cycle after done. The bench drives each request at a falling edge. It then checks every later falling edge in turn against the cycle where a result is due: select, port, write strobe and data while the bytes are on the bus; done and rdata at completion; done low and ready high one cycle after. A behavioural model of the window table and a shadow copy of peripheral storage supply the expected values. That shadow copy is also what exposes writes that went to the wrong place or should have been dropped.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PORT_W = 16;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_RESP = 2'd3
    } pio_state_e;

    typedef struct packed {
        pio_state_e              state;
        logic [PORT_W-1:0]       port;
        logic                    is_word;
        logic                    is_write;
        logic [WORD_W-1:0]       wdata;
        logic [WORD_W-1:0]       rdata;
    } pio_seq_t;

endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter logic [NUM_WIN*PORT_W-1:0] WIN_BASE = '0,
    parameter logic [NUM_WIN*PORT_W-1:0] WIN_SIZE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [PORT_W-1:0]  port,
    output logic [NUM_WIN-1:0] sel
);

    logic [NUM_WIN-1:0] hit;
    logic [NUM_WIN:0]   taken_below;

    assign taken_below[0] = 1'b0;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [PORT_W-1:0] BASE_I = WIN_BASE[i*PORT_W +: PORT_W];
        localparam logic [PORT_W-1:0] SIZE_I = WIN_SIZE[i*PORT_W +: PORT_W];
        logic [PORT_W-1:0] offset;
        assign offset            = port - BASE_I;
        assign hit[i]            = active && (offset < SIZE_I);
        assign sel[i]            = hit[i] && !taken_below[i];
        assign taken_below[i+1]  = taken_below[i] | hit[i];
    end

    // R4: never more than one window selected
    assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
    import pio_pkg::*;
#(
    parameter int NUM_WIN = 3
) (
    input  logic [NUM_WIN-1:0]        sel,
    input  logic [NUM_WIN*BYTE_W-1:0] per_rdata,
    output logic [BYTE_W-1:0]         rd_byte
);

    localparam logic [BYTE_W-1:0] OPEN_BUS = '1;

    logic [BYTE_W-1:0] merged;

    always_comb begin
        merged = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            merged = merged | ({BYTE_W{sel[i]}} & per_rdata[i*BYTE_W +: BYTE_W]);
        end
        rd_byte = (|sel) ? merged : OPEN_BUS;
    end

endmodule

// File: rtl/pio_seq.sv
module pio_seq
    import pio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_word,
    input  logic               req_imm_mode,
    input  logic [BYTE_W-1:0]  req_imm,
    input  logic [PORT_W-1:0]  req_dx,
    input  logic [WORD_W-1:0]  req_wdata,
    input  logic [BYTE_W-1:0]  rd_byte,
    output logic               done,
    output logic [WORD_W-1:0]  rdata,
    output logic               bus_active,
    output logic [PORT_W-1:0]  bus_port,
    output logic               bus_we,
    output logic [BYTE_W-1:0]  bus_wdata
);

    pio_seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state    = ST_LO;
                    r_d.port     = req_imm_mode ? {{(PORT_W-BYTE_W){1'b0}}, req_imm} : req_dx;
                    r_d.is_word  = req_word;
                    r_d.is_write = req_write;
                    r_d.wdata    = req_wdata;
                    r_d.rdata    = '0;
                end
            end
            ST_LO: begin
                if (!r_q.is_write) begin
                    r_d.rdata[BYTE_W-1:0] = rd_byte;
                end
                if (r_q.is_word) begin
                    r_d.state = ST_HI;
                    r_d.port  = r_q.port + 1'b1;
                end else begin
                    r_d.state = ST_RESP;
                end
            end
            ST_HI: begin
                if (!r_q.is_write) begin
                    r_d.rdata[WORD_W-1:BYTE_W] = rd_byte;
                end
                r_d.state = ST_RESP;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, port: '0, is_word: 1'b0, is_write: 1'b0,
                     wdata: '0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.state == ST_IDLE);
    assign done       = (r_q.state == ST_RESP);
    assign rdata      = r_q.rdata;
    assign bus_active = (r_q.state == ST_LO) || (r_q.state == ST_HI);
    assign bus_port   = r_q.port;
    assign bus_we     = bus_active && r_q.is_write;
    assign bus_wdata  = (r_q.state == ST_HI) ? r_q.wdata[WORD_W-1:BYTE_W]
                                             : r_q.wdata[BYTE_W-1:0];

    // R2: an accepted request blocks the next one
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: completion is a single-cycle strobe
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/pio_bus.sv
module pio_bus
    import pio_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter logic [NUM_WIN*PORT_W-1:0] WIN_BASE = {16'hFFFE, 16'h0040, 16'h0042},
    parameter logic [NUM_WIN*PORT_W-1:0] WIN_SIZE = {16'd2, 16'd4, 16'd2}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic                      req_word,
    input  logic                      req_imm_mode,
    input  logic [7:0]                req_imm,
    input  logic [15:0]               req_dx,
    input  logic [15:0]               req_wdata,
    output logic                      done,
    output logic [15:0]               rdata,
    output logic [NUM_WIN-1:0]        per_sel,
    output logic                      per_we,
    output logic [15:0]               per_port,
    output logic [7:0]                per_wdata,
    input  logic [NUM_WIN*8-1:0]      per_rdata
);

    logic              active;
    logic [BYTE_W-1:0] rd_byte;

    pio_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_word     (req_word),
        .req_imm_mode (req_imm_mode),
        .req_imm      (req_imm),
        .req_dx       (req_dx),
        .req_wdata    (req_wdata),
        .rd_byte      (rd_byte),
        .done         (done),
        .rdata        (rdata),
        .bus_active   (active),
        .bus_port     (per_port),
        .bus_we       (per_we),
        .bus_wdata    (per_wdata)
    );

    pio_decode #(
        .NUM_WIN  (NUM_WIN),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .port   (per_port),
        .sel    (per_sel)
    );

    pio_rdmux #(
        .NUM_WIN (NUM_WIN)
    ) u_rdmux (
        .sel       (per_sel),
        .per_rdata (per_rdata),
        .rd_byte   (rd_byte)
    );

    // R8: second byte cycle sits one port above the first, wrapping
    assert_port_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> (per_port == $past(per_port) + 16'd1));

endmodule

// File: tb/pio_bus_test.sv
module pio_bus_test;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 3;
    localparam logic [15:0] W_BASE [NW] = '{16'h0042, 16'h0040, 16'hFFFE};
    localparam logic [15:0] W_SIZE [NW] = '{16'd2, 16'd4, 16'd2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_imm_mode = 1'b0;
    logic [7:0]  req_imm = '0;
    logic [15:0] req_dx = '0, req_wdata = '0;
    logic req_ready, done, per_we;
    logic [15:0] rdata, per_port;
    logic [NW-1:0] per_sel;
    logic [7:0] per_wdata;
    logic [NW*8-1:0] per_rdata;

    logic [7:0] dev [NW][4];
    logic [7:0] shadow [NW][4];

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_bus #(
        .NUM_WIN  (NW),
        .WIN_BASE ({W_BASE[2], W_BASE[1], W_BASE[0]}),
        .WIN_SIZE ({W_SIZE[2], W_SIZE[1], W_SIZE[0]})
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_word(req_word), .req_imm_mode(req_imm_mode),
        .req_imm(req_imm), .req_dx(req_dx), .req_wdata(req_wdata), .done(done),
        .rdata(rdata), .per_sel(per_sel), .per_we(per_we), .per_port(per_port),
        .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

    function automatic logic [1:0] offs(input int w, input logic [15:0] p);
        logic [15:0] d;
        d = p - W_BASE[w];
        return d[1:0];
    endfunction

    // simple peripheral register models
    always_comb begin
        for (int i = 0; i < NW; i++) begin
            per_rdata[i*8 +: 8] = dev[i][offs(i, per_port)];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NW; i++) begin
            if (per_sel[i] && per_we) dev[i][offs(i, per_port)] <= per_wdata;
        end
    end

    // reference model of the window table
    function automatic int exp_win(input logic [15:0] p);
        for (int i = 0; i < NW; i++) begin
            logic [15:0] d;
            d = p - W_BASE[i];
            if (d < W_SIZE[i]) return i;
        end
        return -1;
    endfunction

    function automatic logic [NW-1:0] exp_sel(input logic [15:0] p);
        int w;
        w = exp_win(p);
        return (w < 0) ? '0 : NW'(1 << w);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic txn(input bit wr, input bit wd, input bit imm_mode,
                       input logic [7:0] imm, input logic [15:0] dx,
                       input logic [15:0] wdat);
        logic [15:0] n, p;
        logic [15:0] exp_rd;
        int w;
        n = imm_mode ? {8'h00, imm} : dx;
        exp_rd = 16'h0000;
        @(negedge clk);
        chk("R2", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_word = wd; req_imm_mode = imm_mode;
        req_imm = imm; req_dx = dx; req_wdata = wdat;
        @(negedge clk);
        req_valid = 1'b0;
        req_imm = ~imm; req_dx = ~dx; req_wdata = ~wdat;
        for (int b = 0; b < (wd ? 2 : 1); b++) begin
            p = n + 16'(b);
            w = exp_win(p);
            chk("R2", "ready low while busy", 32'(req_ready), 32'd0);
            chk("R2", "done low during byte cycle", 32'(done), 32'd0);
            chk("R7", "byte cycle port (R3 R8)", 32'(per_port), 32'(p));
            chk("R4", "window select (R6 R9)", 32'(per_sel), 32'(exp_sel(p)));
            chk("R11", "write strobe", 32'(per_we), 32'(wr));
            if (wr) begin
                chk("R7", "write byte lane", 32'(per_wdata), 32'(b ? wdat[15:8] : wdat[7:0]));
                if (w >= 0) shadow[w][offs(w, p)] = b ? wdat[15:8] : wdat[7:0];
            end else begin
                logic [7:0] eb;
                eb = (w < 0) ? 8'hFF : shadow[w][offs(w, p)];  // R5 open bus
                if (b == 0) exp_rd[7:0] = eb; else exp_rd[15:8] = eb;
            end
            @(negedge clk);
        end
        chk("R2", "done strobe", 32'(done), 32'd1);
        chk("R10", "rdata at done (R5 R7)", 32'(rdata), 32'(exp_rd));
        chk("R11", "bus quiet at done", 32'({per_sel, per_we}), 32'd0);
        @(negedge clk);
        chk("R2", "done one cycle only", 32'(done), 32'd0);
        chk("R2", "ready back", 32'(req_ready), 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++)
            for (int k = 0; k < 4; k++) begin
                dev[i][k] = 8'((i << 4) + k + 8'h11);
                shadow[i][k] = dev[i][k];
            end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ready in reset", 32'(req_ready), 32'd1);
        chk("R1", "done in reset", 32'(done), 32'd0);
        chk("R1", "select in reset", 32'(per_sel), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", 32'(req_ready), 32'd1);

        txn(0, 0, 1, 8'h40, 16'h1234, 16'h0);      // R3 immediate port, window 1
        txn(0, 0, 0, 8'h00, 16'h0042, 16'h0);      // R4 overlap, lowest index wins
        txn(1, 0, 0, 8'h00, 16'h0043, 16'h00A5);   // byte write into window 0
        txn(0, 0, 1, 8'h43, 16'h0000, 16'h0);      // read back
        txn(1, 1, 0, 8'h00, 16'h0040, 16'hBEEF);   // R7 word write
        txn(0, 1, 0, 8'h00, 16'h0040, 16'h0);      // R7 word read
        txn(0, 1, 0, 8'h00, 16'h0043, 16'h0);      // R9 mapped low, open-bus high
        txn(1, 1, 0, 8'h00, 16'hFFFF, 16'h7733);   // R8 wrap, high byte dropped
        txn(0, 1, 0, 8'h00, 16'hFFFF, 16'h0);      // R8 wrap read
        txn(1, 0, 0, 8'h00, 16'h1234, 16'h005A);   // R6 unmapped write
        txn(0, 0, 0, 8'h00, 16'h1234, 16'h0);      // R5 unmapped read
        txn(0, 0, 1, 8'hFF, 16'h0040, 16'h0);      // R3 zero-extended 0xFF
        txn(0, 1, 0, 8'h00, 16'hFFFE, 16'h0);      // window 2 both bytes
        // confirm no stray writes landed anywhere (R6)
        for (int i = 0; i < NW; i++)
            for (int k = 0; k < 4; k++)
                if (k < int'(W_SIZE[i]))
                    chk("R6", "peripheral storage", 32'(dev[i][k]), 32'(shadow[i][k]));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule